// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block turns an indirect data-memory access request into an effective address. It owns three 16-bit pointer registers, called X, Y and Z in the port descriptions and selected by the codes 0, 1 and 2. A request names a pointer, an addressing mode and whether it is a load or a store. The block returns the address to drive onto the data bus, a new pointer value with a write-back strobe, and the number of clock cycles the access occupies. While that count runs the block is busy and accepts no new request.

A post-increment access uses the pointer as it stands and then stores the pointer plus one. A pre-decrement access first lowers the pointer and then uses the lowered value as the address. A request flag marks addresses that fall in the non-volatile region. Such accesses take one extra cycle, and a wait line from that side can hold the final cycle for as long as it is asserted. The displacement form (pointer plus offset) is not supported. It is rejected with an illegal-operation pulse and leaves every pointer as it was. The register file loads the pointers through a separate write port.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset all pointers read 0, `req_ready` is 1, and `acc_busy`, `wb_en` and `illegal_op` are 0.
- R2: When `ptr_we` is 1, the pointer chosen by `ptr_wsel` (0 = X, 1 = Y, 2 = Z) takes `ptr_wdata` at the clock edge.
- R3: Mode 0 (plain) drives `acc_addr` with the pointer value one cycle after acceptance, keeps `wb_en` at 0 and leaves the pointer unchanged.
- R4: Mode 1 (post-increment) drives `acc_addr` with the old pointer, pulses `wb_en` with `wb_data` equal to that address plus 1, and the pointer then holds that value.
- R5: Mode 2 (pre-decrement) drives `acc_addr` and `wb_data` both with the pointer minus 1, pulses `wb_en`, and the pointer then holds that value.
- R6: Pointer arithmetic wraps modulo 2^16: 0xFFFF incremented gives 0x0000, and 0x0000 decremented gives 0xFFFF.
- R7: For RAM accesses, `acc_cycles` and the number of cycles `acc_busy` stays high are as follows: a plain load takes 1, a post-increment or pre-decrement load takes 2, a plain or post-increment store takes 1, and a pre-decrement store takes 2.
- R8: When `req_nvm` is 1, the cycle count of R7 grows by one.
- R9: During the last cycle of an NVM access, each cycle with `nvm_wait` high adds one busy cycle. `nvm_wait` has no effect on a RAM access.
- R10: Mode 3 (displacement) or a pointer select of 3 gives a one-cycle `illegal_op` pulse one cycle after acceptance, with no busy period, no `wb_en` and no pointer change.
- R11: While `acc_busy` is 1, `req_ready` is 0 and requests are ignored. They change no pointer.
- R12: If `ptr_we` writes the same pointer that an accepted request writes back in the same cycle, the pointer takes the value from `ptr_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_nvm | input | 1 | Target is in the non-volatile region |
| nvm_wait | input | 1 | Stretch the final cycle of an NVM access |
| ptr_we | input | 1 | Pointer load strobe |
| ptr_wsel | input | 2 | Pointer to load |
| ptr_wdata | input | 16 | Pointer load value |
| acc_busy | output | 1 | Access in progress |
| acc_last | output | 1 | Final cycle of the access |
| acc_addr | output | 16 | Effective data address |
| acc_cycles | output | 2 | Nominal cycle count of the access |
| wb_en | output | 1 | One-cycle pointer write-back strobe |
| wb_sel | output | 2 | Pointer being written back |
| wb_data | output | 16 | New pointer value |
| illegal_op | output | 1 | One-cycle rejection pulse |

## Verification
A stale or wrongly updated pointer cannot be seen on its own. It shows up only in `acc_addr` of the next access that uses that pointer, so the bench follows each post-increment, pre-decrement, rejected or blocked request with a plain access that exposes the stored value one cycle after acceptance. A wrong cycle counter or a mishandled wait shows at the falling edge of `acc_busy`, which the bench times against the count it expects. Address and write-back errors appear in the first busy cycle, one edge after the request.

// File: rtl/pag_pkg.sv
package pag_pkg;
   typedef enum logic [1:0] {
      AM_PLAIN   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_PREDEC  = 2'd2,
      AM_DISP    = 2'd3
   } am_e;
endpackage

// File: rtl/pag_ptr_bank.sv
module pag_ptr_bank #(
   parameter int AW   = 16,
   parameter int NPTR = 3,
   parameter int SW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_we,
   input  logic [SW-1:0] ext_sel,
   input  logic [AW-1:0] ext_data,
   input  logic          upd_we,
   input  logic [SW-1:0] upd_sel,
   input  logic [AW-1:0] upd_data,
   input  logic [SW-1:0] rd_sel,
   output logic [AW-1:0] rd_val
);
   logic [NPTR-1:0][AW-1:0] regs;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic [AW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (ext_we && ext_sel == SW'(g))   // external load wins (R12)
            q <= ext_data;
         else if (upd_we && upd_sel == SW'(g))
            q <= upd_data;
      end
      assign regs[g] = q;
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NPTR; i++)
         if (rd_sel == SW'(i)) rd_val = regs[i];
   end
endmodule

// File: rtl/pag_ea_unit.sv
module pag_ea_unit
   import pag_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 2,
   parameter int NVM_EXTRA = 1
) (
   input  logic [AW-1:0] ptr,
   input  am_e           mode,
   input  logic          store,
   input  logic          nvm,
   input  logic          sel_ok,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] nxt,
   output logic          upd,
   output logic          bad,
   output logic [CW-1:0] cycles
);
   logic [AW-1:0] p_inc, p_dec;
   logic [CW-1:0] base;

   assign p_inc = ptr + AW'(1);   // wraps modulo 2^AW (R6)
   assign p_dec = ptr - AW'(1);

   always_comb begin
      ea   = ptr;
      nxt  = ptr;
      upd  = 1'b0;
      base = CW'(1);
      bad  = !sel_ok;
      case (mode)
         AM_PLAIN: base = CW'(1);
         AM_POSTINC: begin
            nxt  = p_inc;
            upd  = 1'b1;
            base = store ? CW'(1) : CW'(2);
         end
         AM_PREDEC: begin
            ea   = p_dec;
            nxt  = p_dec;
            upd  = 1'b1;
            base = CW'(2);
         end
         default: bad = 1'b1;
      endcase
   end

   if (NVM_EXTRA == 0) begin : g_no_nvm
      logic unused_nvm;
      assign unused_nvm = nvm;
      assign cycles     = base;
   end else begin : g_nvm
      assign cycles = nvm ? base + CW'(NVM_EXTRA) : base;
   end
endmodule

// File: rtl/pag_timer.sv
module pag_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] start_cycles,
   input  logic          start_nvm,
   input  logic          nvm_wait,
   output logic          busy,
   output logic          last
);
   logic [CW-1:0] rem;
   logic          is_nvm;
   logic          hold;

   assign hold = is_nvm && nvm_wait;
   assign last = busy && (rem == '0) && !hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rem    <= '0;
         is_nvm <= 1'b0;
      end else if (start) begin
         busy   <= 1'b1;
         rem    <= start_cycles - CW'(1);
         is_nvm <= start_nvm;
      end else if (busy) begin
         if (rem != '0)
            rem <= rem - CW'(1);
         else if (!hold)
            busy <= 1'b0;
      end
   end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
   import pag_pkg::*;
#(
   parameter int AW        = 16,
   parameter int NPTR      = 3,
   parameter int NVM_EXTRA = 1,
   localparam int SW       = (NPTR > 1) ? $clog2(NPTR + 1) : 1,
   localparam int MAXC     = 2 + NVM_EXTRA,
   localparam int CW       = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [SW-1:0] req_sel,
   input  logic [1:0]    req_mode,
   input  logic          req_store,
   input  logic          req_nvm,
   input  logic          nvm_wait,
   input  logic          ptr_we,
   input  logic [SW-1:0] ptr_wsel,
   input  logic [AW-1:0] ptr_wdata,
   output logic          acc_busy,
   output logic          acc_last,
   output logic [AW-1:0] acc_addr,
   output logic [CW-1:0] acc_cycles,
   output logic          wb_en,
   output logic [SW-1:0] wb_sel,
   output logic [AW-1:0] wb_data,
   output logic          illegal_op
);
   initial begin
      if (AW < 4 || NPTR < 1 || NPTR > 7 || NVM_EXTRA < 0 || NVM_EXTRA > 4)
         $fatal(1, "ptr_addr_gen: parameter out of range");
   end

   logic          accept, sel_ok, go;
   logic [AW-1:0] ptr_val, ea, nxt;
   logic          upd, bad;
   logic [CW-1:0] cyc;

   assign req_ready = !acc_busy;
   assign accept    = req_valid && req_ready;
   assign sel_ok    = int'(req_sel) < NPTR;
   assign go        = accept && !bad;

   pag_ptr_bank #(.AW(AW), .NPTR(NPTR), .SW(SW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ext_we(ptr_we), .ext_sel(ptr_wsel), .ext_data(ptr_wdata),
      .upd_we(go && upd), .upd_sel(req_sel), .upd_data(nxt),
      .rd_sel(req_sel), .rd_val(ptr_val)
   );

   pag_ea_unit #(.AW(AW), .CW(CW), .NVM_EXTRA(NVM_EXTRA)) u_ea (
      .ptr(ptr_val), .mode(am_e'(req_mode)), .store(req_store),
      .nvm(req_nvm), .sel_ok(sel_ok),
      .ea(ea), .nxt(nxt), .upd(upd), .bad(bad), .cycles(cyc)
   );

   pag_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(go), .start_cycles(cyc), .start_nvm(req_nvm),
      .nvm_wait(nvm_wait), .busy(acc_busy), .last(acc_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_addr   <= '0;
         acc_cycles <= '0;
         wb_en      <= 1'b0;
         wb_sel     <= '0;
         wb_data    <= '0;
         illegal_op <= 1'b0;
      end else begin
         wb_en      <= 1'b0;
         illegal_op <= 1'b0;
         if (accept) begin
            if (bad) begin
               illegal_op <= 1'b1;
            end else begin
               acc_addr   <= ea;
               acc_cycles <= cyc;
               wb_en      <= upd;
               wb_sel     <= req_sel;
               wb_data    <= nxt;
            end
         end
      end
   end
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
   parameter int AW = 16,
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [1:0]    req_mode,
   input logic          req_nvm,
   input logic          acc_busy,
   input logic          acc_last,
   input logic [AW-1:0] acc_addr,
   input logic [CW-1:0] acc_cycles,
   input logic          wb_en,
   input logic [AW-1:0] wb_data,
   input logic          illegal_op
);
   p_plain_nowb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_ready && req_mode == 2'd0) |-> !wb_en);

   p_postinc_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_ready && req_mode == 2'd1) && !illegal_op
      |-> wb_en && (wb_data == acc_addr + AW'(1)));

   p_predec_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_ready && req_mode == 2'd2) && !illegal_op
      |-> wb_en && (wb_data == acc_addr));

   p_predec_ram_cycles_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_ready && req_mode == 2'd2 && !req_nvm) && !illegal_op
      |-> acc_cycles == CW'(2));

   p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_last |=> !acc_busy);

   p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> !acc_busy && !wb_en);

   p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_busy |-> !req_ready);

   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_busy) |-> $past(req_valid && req_ready));
endmodule

bind ptr_addr_gen pag_checker #(.AW(AW), .CW(CW)) u_pag_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_mode(req_mode), .req_nvm(req_nvm), .acc_busy(acc_busy),
   .acc_last(acc_last), .acc_addr(acc_addr), .acc_cycles(acc_cycles),
   .wb_en(wb_en), .wb_data(wb_data), .illegal_op(illegal_op)
);

// File: tb/test_ptr_addr_gen.sv
module test_ptr_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_sel = '0;
   logic [1:0]  req_mode = '0;
   logic        req_store = 1'b0;
   logic        req_nvm = 1'b0;
   logic        nvm_wait = 1'b0;
   logic        ptr_we = 1'b0;
   logic [1:0]  ptr_wsel = '0;
   logic [15:0] ptr_wdata = '0;
   logic        acc_busy, acc_last, wb_en, illegal_op;
   logic [15:0] acc_addr, wb_data;
   logic [1:0]  acc_cycles, wb_sel;

   always #5 clk = ~clk;

   ptr_addr_gen i_ptr_addr_gen (.*);

   typedef struct {
      logic [15:0] addr;
      logic        wben;
      logic [15:0] wbval;
      int          cyc;
      int          dur;
      logic        ill;
      string       tag;
   } item_t;

   item_t       sb[$];
   item_t       cur;
   logic [15:0] mp[3];
   int          n_chk = 0;
   int          n_fail = 0;
   logic        prev_busy = 1'b0;
   int          dcnt = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (illegal_op) begin
            if (sb.size() == 0) chk(0, "R10 unexpected illegal", 1, 0);
            else begin
               cur = sb.pop_front();
               chk(cur.ill == 1'b1, {cur.tag, " illegal"}, 1, longint'(cur.ill));
               chk(!acc_busy && !wb_en, {cur.tag, " quiet"}, longint'({acc_busy, wb_en}), 0);
            end
         end
         if (acc_busy && !prev_busy) begin
            if (sb.size() == 0) chk(0, "R11 unexpected access", 1, 0);
            else begin
               cur = sb.pop_front();
               chk(cur.ill == 1'b0, {cur.tag, " accepted"}, 0, longint'(cur.ill));
               chk(acc_addr == cur.addr, {cur.tag, " addr"}, acc_addr, cur.addr);
               chk(wb_en == cur.wben, {cur.tag, " wb_en"}, wb_en, cur.wben);
               if (cur.wben)
                  chk(wb_data == cur.wbval, {cur.tag, " wb_data"}, wb_data, cur.wbval);
               chk(int'(acc_cycles) == cur.cyc, {cur.tag, " cycles"}, acc_cycles, cur.cyc);
            end
            dcnt = 1;
         end else if (acc_busy) begin
            dcnt++;
         end
         if (!acc_busy && prev_busy)
            chk(dcnt == cur.dur, {cur.tag, " busy length"}, dcnt, cur.dur);
         prev_busy = acc_busy;
      end
   end

   task automatic wr_ptr(input logic [1:0] s, input logic [15:0] v);
      ptr_we = 1'b1; ptr_wsel = s; ptr_wdata = v;
      @(negedge clk);
      ptr_we = 1'b0;
      mp[s] = v;
   endtask

   task automatic issue(input logic [1:0] s, input logic [1:0] m, input bit st, input bit nvm,
                        input int waitn, input bit intrude, input bit ext_en,
                        input logic [15:0] ext_val, input string tag);
      item_t it;
      int    base, cnt;
      logic [15:0] p;
      it.tag = tag;
      it.ill = (m == 2'd3) || (s == 2'd3);
      p = (s == 2'd3) ? 16'h0 : mp[s];
      it.addr = (m == 2'd2) ? p - 16'd1 : p;
      it.wben = (m != 2'd0);
      it.wbval = (m == 2'd1) ? p + 16'd1 : p - 16'd1;
      base = (m == 2'd0) ? 1 : (m == 2'd2) ? 2 : (st ? 1 : 2);
      it.cyc = base + (nvm ? 1 : 0);
      it.dur = it.cyc + (nvm ? waitn : 0);
      sb.push_back(it);
      if (!it.ill && m != 2'd0) mp[s] = it.wbval;
      if (ext_en) begin
         ptr_we = 1'b1; ptr_wsel = s; ptr_wdata = ext_val;
         mp[s] = ext_val;   // R12: external load wins
      end
      req_valid = 1'b1; req_sel = s; req_mode = m; req_store = st; req_nvm = nvm;
      @(negedge clk);
      req_valid = 1'b0; ptr_we = 1'b0;
      cnt = 0;
      while (acc_busy) begin
         cnt++;
         nvm_wait = (cnt <= it.cyc - 1 + waitn);
         if (intrude && cnt == 1) begin
            chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
            req_valid = 1'b1; req_sel = 2'd1; req_mode = 2'd1;
         end
         if (intrude && cnt == 2) req_valid = 1'b0;
         @(negedge clk);
      end
      nvm_wait = 1'b0;
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic show(input logic [1:0] s, input string tag);
      issue(s, 2'd0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 16'h0, tag);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 3; i++) mp[i] = 16'h0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk(acc_busy == 1'b0, "R1 busy", acc_busy, 0);
      chk(wb_en == 1'b0 && illegal_op == 1'b0, "R1 pulses", longint'({wb_en, illegal_op}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      show(2'd0, "R1 X zero");
      show(2'd2, "R1 Z zero");
      // R2 pointer loads
      wr_ptr(2'd0, 16'h1000);
      wr_ptr(2'd1, 16'h2000);
      wr_ptr(2'd2, 16'h3000);
      show(2'd0, "R2 X");
      show(2'd1, "R2 Y");
      show(2'd2, "R2 Z");
      // R3 plain store leaves Z
      issue(2'd2, 2'd0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R3 plain store");
      show(2'd2, "R3 Z unchanged");
      // R4 post-increment
      issue(2'd1, 2'd1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R4 postinc load");
      show(2'd1, "R4 Y bumped");
      issue(2'd0, 2'd1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R7 postinc store");
      // R5 pre-decrement
      issue(2'd2, 2'd2, 1'b0, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R5 predec load");
      issue(2'd0, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R5 predec store");
      show(2'd2, "R5 Z lowered");
      // R6 wrap
      wr_ptr(2'd0, 16'hFFFF);
      issue(2'd0, 2'd1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R6 inc wrap");
      show(2'd0, "R6 X at zero");
      issue(2'd0, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R6 dec wrap");
      show(2'd0, "R6 X at FFFF");
      // R8 NVM extra cycle
      issue(2'd1, 2'd0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 16'h0, "R8 nvm plain load");
      issue(2'd1, 2'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 16'h0, "R8 nvm postinc load");
      issue(2'd2, 2'd2, 1'b1, 1'b1, 0, 1'b0, 1'b0, 16'h0, "R8 nvm predec store");
      issue(2'd2, 2'd1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 16'h0, "R8 nvm postinc store");
      // R9 wait stretching and RAM immunity
      issue(2'd0, 2'd2, 1'b0, 1'b1, 3, 1'b0, 1'b0, 16'h0, "R9 nvm wait 3");
      issue(2'd1, 2'd0, 1'b0, 1'b1, 1, 1'b0, 1'b0, 16'h0, "R9 nvm wait 1");
      issue(2'd1, 2'd2, 1'b0, 1'b0, 4, 1'b0, 1'b0, 16'h0, "R9 ram ignores wait");
      // R10 rejection
      issue(2'd1, 2'd3, 1'b0, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R10 disp mode");
      issue(2'd3, 2'd1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0, "R10 bad select");
      show(2'd1, "R10 Y untouched");
      // R11 request during busy ignored
      issue(2'd0, 2'd0, 1'b0, 1'b1, 2, 1'b1, 1'b0, 16'h0, "R11 long access");
      show(2'd1, "R11 Y untouched");
      // R12 collision
      issue(2'd2, 2'd1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 16'h4321, "R12 collide");
      show(2'd2, "R12 Z from load port");
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
      finish_run();
   end
endmodule